// File: doc/BRIEF.md
# Actuator Driver Power-Mode Controller

This block decides the power state of an actuator driver: shutdown, standby or active. An external enable pin and a small register file together choose the state. The register file sits behind a simple strobe port. Register 0 is the mode register. It holds a standby flag, which comes out of reset set, and a self-clearing soft-reset bit. The remaining registers carry general settings, and each has a fixed default value.

When the enable pin is low, the block is forced into shutdown. Register contents survive shutdown. Every access is still acknowledged, but no access takes effect. Setting the standby flag leaves active at once. Clearing it, with enable high, returns the block to active. Writing the soft-reset bit acts like a power cycle: all defaults are reloaded and the block falls back to standby. Any exit from active raises a one-cycle playback-abort pulse for the waveform engine.

Top module: `haptic_power_ctl`

## Requirements
- R1: The enable pin passes through a two-flop synchronizer. When the pin goes low, `pwrState` reads shutdown (encoding 0) from the third rising edge after the fall, whatever the register bits hold. Standby is encoding 1 and active is encoding 2. `deepSleep` is high exactly in shutdown and `lightSleep` is high exactly in standby.
- R2: Shutdown clears no register. After enable returns, every register reads back the value it held before.
- R3: Each access strobe is acknowledged by `regAck` one cycle later, even while enable is low. While the synchronized enable is low, writes are dropped, and a read returns `regRdValid`=0 with `regRdata`=0.
- R4: While `rstN` is low the state is shutdown. After release with enable high, the state reaches standby by the third edge. Register 0 then reads 0x01 and register i (i≥1) reads (17·i) mod 256.
- R5: Writing register 0 with bit 0 set moves active to standby at the edge that takes the write. Register contents and register access are unchanged in standby.
- R6: Writing register 0 with bit 0 clear, while enable is high, moves the block to active at the edge that takes the write.
- R7: Writing register 0 with bit 7 set reloads every register default, including standby bit 0 set to 1. At the same edge it moves the block to standby and raises `defaultsLoad` for one cycle.
- R8: After a soft reset, bit 7 of register 0 reads 1 for reads sampled on the 4 edges following the write, and 0 after that. Writes sampled on those edges are ignored.
- R9: `playAbort` is a one-cycle pulse raised exactly when the state leaves active, for any cause.
- R10: A register write sampled at the same edge as the first low synchronized enable is discarded, and shutdown is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enPin | input | 1 | Asynchronous enable pin |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 8 | Write data |
| regAck | output | 1 | Access acknowledge, one cycle after the strobe |
| regRdValid | output | 1 | Read data valid |
| regRdata | output | 8 | Read data |
| pwrState | output | 2 | 0 shutdown, 1 standby, 2 active |
| playAbort | output | 1 | One-cycle playback-abort pulse |
| defaultsLoad | output | 1 | One-cycle pulse after a soft reset |
| deepSleep | output | 1 | High in shutdown |
| lightSleep | output | 1 | High in standby |

## Verification
A wrong state encoding or a missed transition shows on `pwrState` and the sleep flags on the edge that takes the write, or on the third edge after an enable fall. A lost or duplicated abort shows on `playAbort` in that same cycle. A register clobbered by shutdown, by a blocked write or by a write during the reset window only appears on a later read-back. For that reason the bench reads the whole file after each such event. A busy window of the wrong length is caught by reads on each edge across the window and the edge just after it.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    PWR_SHUT = 2'd0,
    PWR_STBY = 2'd1,
    PWR_ACT  = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic loadDefaults;
  } hpcStrobes_t;

  localparam int STBY_BIT = 0;
  localparam int SRST_BIT = 7;

  function automatic logic [7:0] regDefault(input int idx);
    int prod;
    prod = idx * 17;
    return (idx == 0) ? 8'h01 : prod[7:0];
  endfunction
endpackage

// File: rtl/hpc_control.sv
module hpc_control
  import hpc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enPin,
  input  logic        regWr,
  input  logic        regRd,
  input  logic        ctrlHit,
  input  logic        wrStby,
  input  logic        wrSrst,
  input  logic        standbyBit,
  output hpcStrobes_t strobes,
  output logic        busy,
  output pwrState_t   state,
  output logic        playAbort,
  output logic        defaultsLoad,
  output logic        regAck,
  output logic        regRdValid
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic enMeta, enSync;
  logic [CNT_W-1:0] rstCnt;
  logic wrAccepted, devRst, stbyNext;
  pwrState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMeta <= 1'b0;
      enSync <= 1'b0;
    end else begin
      enMeta <= enPin;
      enSync <= enMeta;
    end
  end

  assign busy       = (rstCnt != '0);
  assign wrAccepted = regWr && enSync && !busy;
  assign devRst     = wrAccepted && ctrlHit && wrSrst;

  always_comb begin
    strobes.wrEn         = wrAccepted && !devRst;
    strobes.rdEn         = regRd && enSync;
    strobes.loadDefaults = devRst;
  end

  always_comb begin
    if (devRst)                        stbyNext = 1'b1;
    else if (strobes.wrEn && ctrlHit)  stbyNext = wrStby;
    else                               stbyNext = standbyBit;
  end

  always_comb begin
    if (!enSync)       nextState = PWR_SHUT;
    else if (stbyNext) nextState = PWR_STBY;
    else               nextState = PWR_ACT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= PWR_SHUT;
      playAbort    <= 1'b0;
      defaultsLoad <= 1'b0;
      rstCnt       <= '0;
      regAck       <= 1'b0;
      regRdValid   <= 1'b0;
    end else begin
      state        <= nextState;
      playAbort    <= (state == PWR_ACT) && (nextState != PWR_ACT);
      defaultsLoad <= devRst;
      if (devRst)    rstCnt <= CNT_LOAD;
      else if (busy) rstCnt <= rstCnt - 1'b1;
      regAck       <= regWr || regRd;
      regRdValid   <= strobes.rdEn;
    end
  end

  assert_shut_when_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enSync |=> state == PWR_SHUT);
  assert_ack_always_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr || regRd) |=> regAck);
  assert_read_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !enSync) |=> !regRdValid);
  assert_reset_to_standby_R7: assert property (@(posedge clk) disable iff (!rstN)
    (devRst && enSync) |=> (state == PWR_STBY) && defaultsLoad);
  assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    playAbort |=> !playAbort);
  assert_abort_on_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    playAbort |-> ($past(state) == PWR_ACT) && (state != PWR_ACT));
endmodule

// File: rtl/hpc_regs.sv
module hpc_regs
  import hpc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output logic [7:0]        rdData,
  output logic              standbyBit
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [7:0] regView [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     standbyBit <= 1'b1;
    else if (strobes.loadDefaults) standbyBit <= 1'b1;
    else if (strobes.wrEn && addr == '0) standbyBit <= wrData[STBY_BIT];
  end

  always_comb begin
    regView[0]           = 8'h00;
    regView[0][STBY_BIT] = standbyBit;
    regView[0][SRST_BIT] = busy;
  end

  for (genvar i = 1; i < NUM_REGS; i++) begin : gReg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     q <= regDefault(i);
      else if (strobes.loadDefaults) q <= regDefault(i);
      else if (strobes.wrEn && addr == ADDR_W'(i)) q <= wrData;
    end
    assign regView[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= 8'h00;
    else if (strobes.rdEn) rdData <= regView[addr];
    else                   rdData <= 8'h00;
  end

  assert_no_write_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.wrEn && !strobes.loadDefaults);
  assert_defaults_set_standby_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadDefaults |=> standbyBit);
endmodule

// File: rtl/haptic_power_ctl.sv
module haptic_power_ctl
  import hpc_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPin,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic              regAck,
  output logic              regRdValid,
  output logic [7:0]        regRdata,
  output logic [1:0]        pwrState,
  output logic              playAbort,
  output logic              defaultsLoad,
  output logic              deepSleep,
  output logic              lightSleep
);
  hpcStrobes_t strobes;
  pwrState_t   state;
  logic        busy, standbyBit;

  hpc_control #(.RST_CYCLES(RST_CYCLES)) uControl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .regWr(regWr), .regRd(regRd),
    .ctrlHit(regAddr == '0), .wrStby(regWdata[STBY_BIT]), .wrSrst(regWdata[SRST_BIT]),
    .standbyBit(standbyBit), .strobes(strobes), .busy(busy), .state(state),
    .playAbort(playAbort), .defaultsLoad(defaultsLoad), .regAck(regAck),
    .regRdValid(regRdValid)
  );

  hpc_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(regAddr), .wrData(regWdata),
    .busy(busy), .rdData(regRdata), .standbyBit(standbyBit)
  );

  assign pwrState   = state;
  assign deepSleep  = (state == PWR_SHUT);
  assign lightSleep = (state == PWR_STBY);
endmodule

// File: tb/haptic_power_ctl_test.sv
module haptic_power_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, enPin = 1'b1, regWr = 1'b0, regRd = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic regAck, regRdValid, playAbort, defaultsLoad, deepSleep, lightSleep;
  logic [7:0] regRdata;
  logic [1:0] pwrState;
  int nVec = 0, nErr = 0;
  logic [7:0] shadow [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  haptic_power_ctl #(.ADDR_W(AW), .RST_CYCLES(4)) uut (
    .clk(clk), .rstN(rstN), .enPin(enPin), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck), .regRdValid(regRdValid),
    .regRdata(regRdata), .pwrState(pwrState), .playAbort(playAbort),
    .defaultsLoad(defaultsLoad), .deepSleep(deepSleep), .lightSleep(lightSleep));

  function automatic logic [7:0] expDef(int i);
    int p;
    p = i * 17;
    return (i == 0) ? 8'h01 : p[7:0];
  endfunction

  task automatic check(string tag, int act, int exp);
    nVec++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkState(string tag, int exp);
    check(tag, pwrState, exp);
    check({tag, " deepSleep"}, deepSleep, exp == 0);
    check({tag, " lightSleep"}, lightSleep, exp == 1);
  endtask

  task automatic doWrite(int a, int d);
    regWr = 1'b1; regAddr = AW'(a); regWdata = d[7:0];
    tick();
    regWr = 1'b0;
  endtask

  task automatic doRead(int a, output logic [7:0] d, output logic v, output logic k);
    regRd = 1'b1; regAddr = AW'(a);
    tick();
    d = regRdata; v = regRdValid; k = regAck;
    regRd = 1'b0;
  endtask

  task automatic readAll(string tag);
    logic [7:0] d; logic v, k;
    for (int i = 0; i < NREG; i++) begin
      doRead(i, d, v, k);
      check({tag, " valid"}, v, 1);
      check(tag, d, shadow[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nErr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v, k;
    tick(); tick();
    checkState("R4 in reset", 0);
    rstN = 1'b1;
    tick(); tick(); tick();
    checkState("R4 standby after reset", 1);
    for (int i = 0; i < NREG; i++) shadow[i] = expDef(i);
    readAll("R4 default");

    for (int i = 1; i < NREG; i++) begin
      shadow[i] = 8'((i * 37 + 5) & 255);
      doWrite(i, shadow[i]);
    end
    readAll("R5 standby access");

    doWrite(0, 8'h00); shadow[0] = 8'h00;
    checkState("R6 go active", 2);
    check("R9 no abort on entry", playAbort, 0);

    doWrite(0, 8'h01); shadow[0] = 8'h01;
    checkState("R5 to standby", 1);
    check("R9 abort on standby", playAbort, 1);
    tick();
    check("R9 abort one cycle", playAbort, 0);
    readAll("R5 contents kept");

    doWrite(0, 8'h00); shadow[0] = 8'h00;
    checkState("R6 active again", 2);
    enPin = 1'b0;
    tick(); checkState("R1 edge1", 2);
    tick(); checkState("R1 edge2", 2);
    tick(); checkState("R1 edge3 shutdown", 0);
    check("R9 abort on shutdown", playAbort, 1);
    tick();
    check("R9 abort cleared", playAbort, 0);
    doWrite(1, 8'hEE);
    check("R3 write ack", regAck, 1);
    doWrite(0, 8'h01);
    checkState("R1 stays shutdown", 0);
    doRead(1, d, v, k);
    check("R3 read ack", k, 1);
    check("R3 read invalid", v, 0);
    check("R3 read zero", d, 0);
    enPin = 1'b1;
    tick(); tick(); tick();
    checkState("R2 back active", 2);
    readAll("R2 R3 kept");

    enPin = 1'b0;
    tick(); tick();
    doWrite(0, 8'h01);
    checkState("R10 shutdown wins", 0);
    check("R10 abort", playAbort, 1);
    enPin = 1'b1;
    tick(); tick(); tick();
    checkState("R10 write dropped", 2);
    readAll("R10 regs");

    doWrite(0, 8'h80);
    checkState("R7 soft reset standby", 1);
    check("R9 abort on soft reset", playAbort, 1);
    check("R7 defaultsLoad", defaultsLoad, 1);
    doRead(0, d, v, k); check("R8 busy edge1", d, 8'h81);
    check("R7 defaultsLoad pulse", defaultsLoad, 0);
    doWrite(2, 8'h5A);
    doRead(0, d, v, k); check("R8 busy edge3", d, 8'h81);
    doRead(0, d, v, k); check("R8 busy edge4", d, 8'h81);
    doRead(0, d, v, k); check("R8 cleared edge5", d, 8'h01);
    for (int i = 0; i < NREG; i++) shadow[i] = expDef(i);
    readAll("R7 R8 defaults");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule